// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block tracks a single address reservation for one processor core so that a load-exclusive / store-exclusive pair can form an atomic read-modify-write. A load-exclusive arms the reservation and records the word address. A later store-exclusive is allowed to reach memory only if the reservation is still armed for that same word. In the same cycle as the store request, the block returns a fail flag (0 = success, 1 = retry) and a write-enable for the memory.

Every store-exclusive disarms the monitor, whether it succeeds or fails. A clear request also disarms it. Exception entry disarms it when the clear-on-exception mode input is high, so interrupt handlers never need an explicit clear. When that mode input is low, the reservation survives exceptions and software must clear it itself. The memory, the bus, any multi-master monitor and ordering barriers are outside this block.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is disarmed (`resv_held`=0). While `st_req` is low, `st_fail` and `st_wr_en` are both 0.
- R2: A load-exclusive (`ld_req`=1) with no store, clear or enabled exception in the same cycle arms the monitor from the next clock edge and records the address as the tag.
- R3: A store-exclusive while armed, to the tagged word, gives `st_fail`=0 and `st_wr_en`=1 in the same cycle as the request.
- R4: Every store-exclusive disarms the monitor from the next clock edge, whether it passes or fails.
- R5: A store-exclusive while disarmed gives `st_fail`=1 and `st_wr_en`=0.
- R6: A store-exclusive to a word other than the tagged one gives `st_fail`=1 and `st_wr_en`=0, and still disarms the monitor.
- R7: The tag comparison ignores the lowest `GRAN_BITS` address bits (2 by default), so byte offsets inside one word match.
- R8: A new load-exclusive while armed replaces the tag. A store to the old word then fails, and a store to the new word passes.
- R9: A clear request (`clr_req`) disarms the monitor from the next edge and never asserts `st_wr_en`.
- R10: With `exc_clr_mode`=1, an `exc_entry` pulse disarms the monitor. A store-exclusive in the same cycle as that pulse fails with no write.
- R11: With `exc_clr_mode`=0, an `exc_entry` pulse leaves the reservation and the tag unchanged.
- R12: A load-exclusive in the same cycle as a store, a clear, or an enabled exception entry is overridden, and the monitor ends disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_req | input | 1 | Load-exclusive request |
| st_req | input | 1 | Store-exclusive request |
| clr_req | input | 1 | Clear-reservation request |
| addr | input | ADDR_W | Byte address of the request |
| exc_entry | input | 1 | Exception-entry pulse |
| exc_clr_mode | input | 1 | 1: exception entry clears the reservation |
| st_fail | output | 1 | Store status: 0 = pass, 1 = fail (valid while st_req is high) |
| st_wr_en | output | 1 | Lets the store reach memory |
| resv_held | output | 1 | Monitor armed |

## Verification
The bench builds the block with ADDR_W=12 and GRAN_BITS=2. This keeps the addresses short enough to choose words that differ only in the top bit, or only in the ignored offset bits. That reaches both the mismatch path and the match path at the edges of the compared field. The bench also runs a read-modify-write increment on a small memory array. In that sequence an interrupt-style load to another word intervenes, once with the clear-on-exception mode set and once with it cleared.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic              st_req,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              exc_entry,
  input  logic              exc_clr_mode,
  output logic              st_fail,
  output logic              st_wr_en,
  output logic              resv_held
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [TAG_W-1:0] tag_q;
  logic             held_q;
  logic             exc_kill;
  logic             tag_hit;
  logic             pass;
  logic             drop;
  logic             arm;

  assign exc_kill = exc_entry & exc_clr_mode;
  assign tag_hit  = (addr[ADDR_W-1:GRAN_BITS] == tag_q);
  assign pass     = st_req & held_q & tag_hit & ~exc_kill;

  assign st_wr_en  = pass;
  assign st_fail   = st_req & ~pass;
  assign resv_held = held_q;

  assign drop = st_req | clr_req | exc_kill;
  assign arm  = ld_req & ~drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tag_q  <= '0;
    end else if (drop) begin
      held_q <= 1'b0;
    end else if (arm) begin
      held_q <= 1'b1;
      tag_q  <= addr[ADDR_W-1:GRAN_BITS];
    end
  end
endmodule

module excl_monitor_chk #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_req,
  input logic              st_req,
  input logic              clr_req,
  input logic [ADDR_W-1:0] addr,
  input logic              exc_entry,
  input logic              exc_clr_mode,
  input logic              st_fail,
  input logic              st_wr_en,
  input logic              resv_held
);
  a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req |-> (!st_fail && !st_wr_en));
  a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !st_req && !clr_req && !(exc_entry && exc_clr_mode)) |=> resv_held);
  a_r3_pass_xor_fail: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> (st_fail != st_wr_en));
  a_r4_store_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |=> !resv_held);
  a_r5_open_store_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !resv_held) |-> (st_fail && !st_wr_en));
  a_r9_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !resv_held);
  a_r10_exc_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && exc_clr_mode) |=> !resv_held);
  a_r10_exc_store_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && exc_clr_mode && st_req) |-> (st_fail && !st_wr_en));
  a_r11_exc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && !exc_clr_mode && resv_held && !ld_req && !st_req && !clr_req)
      |=> resv_held);
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_chk (.*);

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_req = 1'b0, st_req = 1'b0, clr_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          exc_entry = 1'b0, exc_clr_mode = 1'b1;
  logic          st_fail, st_wr_en, resv_held;
  logic          f_s, w_s;
  int            total = 0, bad = 0;
  logic [7:0]    mem [4];

  always #2 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRAN_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .st_req(st_req), .clr_req(clr_req),
    .addr(addr), .exc_entry(exc_entry), .exc_clr_mode(exc_clr_mode),
    .st_fail(st_fail), .st_wr_en(st_wr_en), .resv_held(resv_held));

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic op(input logic l, input logic s, input logic c, input logic e,
                    input logic [AW-1:0] a);
    @(negedge clk);
    ld_req = l; st_req = s; clr_req = c; exc_entry = e; addr = a;
    #1;
    f_s = st_fail; w_s = st_wr_en;
    @(posedge clk); #1;
    ld_req = 0; st_req = 0; clr_req = 0; exc_entry = 0;
  endtask

  task automatic t_reset;
    chk("R1 held after reset", resv_held, 0);
    op(0, 0, 0, 0, 12'h040);
    chk("R1 fail idle", f_s, 0);
    chk("R1 wr idle", w_s, 0);
  endtask

  task automatic t_basic;
    op(1, 0, 0, 0, 12'h100);
    chk("R2 armed", resv_held, 1);
    op(0, 1, 0, 0, 12'h100);
    chk("R3 pass fail", f_s, 0);
    chk("R3 pass wr", w_s, 1);
    chk("R4 disarm after pass", resv_held, 0);
    op(0, 1, 0, 0, 12'h100);
    chk("R5 open fail", f_s, 1);
    chk("R5 open wr", w_s, 0);
  endtask

  task automatic t_mismatch;
    op(1, 0, 0, 0, 12'h004);
    op(0, 1, 0, 0, 12'h804);
    chk("R6 mismatch fail", f_s, 1);
    chk("R6 mismatch wr", w_s, 0);
    chk("R6 disarm", resv_held, 0);
    op(1, 0, 0, 0, 12'h7F0);
    op(0, 1, 0, 0, 12'h7F3);
    chk("R7 offset match wr", w_s, 1);
    op(1, 0, 0, 0, 12'h7F0);
    op(0, 1, 0, 0, 12'h7F4);
    chk("R7 next word fail", f_s, 1);
  endtask

  task automatic t_replace;
    op(1, 0, 0, 0, 12'h010);
    op(1, 0, 0, 0, 12'h020);
    op(0, 1, 0, 0, 12'h010);
    chk("R8 old tag fail", f_s, 1);
    op(1, 0, 0, 0, 12'h010);
    op(1, 0, 0, 0, 12'h020);
    op(0, 1, 0, 0, 12'h020);
    chk("R8 new tag pass", w_s, 1);
    chk("R4 disarm after R8", resv_held, 0);
  endtask

  task automatic t_clear;
    op(1, 0, 0, 0, 12'h030);
    op(0, 0, 1, 0, 12'h030);
    chk("R9 clr wr", w_s, 0);
    chk("R9 clr disarm", resv_held, 0);
    op(0, 1, 0, 0, 12'h030);
    chk("R9 store after clr fails", f_s, 1);
  endtask

  task automatic t_exc;
    exc_clr_mode = 1;
    op(1, 0, 0, 0, 12'h044);
    op(0, 0, 0, 1, 12'h000);
    chk("R10 exc disarm", resv_held, 0);
    op(1, 0, 0, 0, 12'h044);
    op(0, 1, 0, 1, 12'h044);
    chk("R10 exc+st fail", f_s, 1);
    chk("R10 exc+st wr", w_s, 0);
    exc_clr_mode = 0;
    op(1, 0, 0, 0, 12'h048);
    op(0, 0, 0, 1, 12'h000);
    chk("R11 exc keeps", resv_held, 1);
    op(0, 1, 0, 0, 12'h048);
    chk("R11 tag kept pass", w_s, 1);
    exc_clr_mode = 1;
  endtask

  task automatic t_collide;
    op(1, 1, 0, 0, 12'h050);
    chk("R12 ld+st open", resv_held, 0);
    op(1, 0, 1, 0, 12'h050);
    chk("R12 ld+clr open", resv_held, 0);
    op(1, 0, 0, 1, 12'h050);
    chk("R12 ld+exc open", resv_held, 0);
  endtask

  task automatic t_rmw;
    logic [7:0] v;
    mem[0] = 8'd5; mem[1] = 8'd9;
    exc_clr_mode = 1;
    op(1, 0, 0, 0, 12'h000); v = mem[0] + 1;
    op(0, 0, 0, 1, 12'h000);
    op(0, 1, 0, 0, 12'h000); if (w_s) mem[0] = v;
    chk("R10 rmw retry needed", f_s, 1);
    op(1, 0, 0, 0, 12'h000); v = mem[0] + 1;
    op(0, 1, 0, 0, 12'h000); if (w_s) mem[0] = v;
    chk("R3 rmw result", mem[0] == 8'd6, 1);
    exc_clr_mode = 0;
    op(1, 0, 0, 0, 12'h000); v = mem[0] + 1;
    op(0, 0, 0, 1, 12'h000);
    op(1, 0, 0, 0, 12'h004);
    op(0, 1, 0, 0, 12'h004); if (w_s) mem[1] = mem[1] + 1;
    op(0, 1, 0, 0, 12'h000); if (w_s) mem[0] = v;
    chk("R8 handler stole tag", mem[0] == 8'd6 && mem[1] == 8'd10, 1);
    exc_clr_mode = 1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset(); t_basic(); t_mismatch(); t_replace();
        t_clear(); t_exc(); t_collide(); t_rmw();
      end
      begin
        repeat (5000) @(posedge clk);
        chk("watchdog", 1'b1, 1'b0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule